// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits on the transmit byte stream ahead of the MAC. It takes in a whole frame, keeping it in a local buffer, and builds a 16-bit ones'-complement sum as the bytes arrive. Once the frame is complete it folds that sum and, if the frame asked for it, writes the complemented result over two bytes of the buffered frame. The patched frame is then sent out as one unbroken burst. Three sideband words arrive with the first byte of each frame. They carry the insertion enable, where summation starts, where the result is written, and a seed value that is added into the sum.

Frames are also filtered. A frame is dropped when transmission is disabled, when it is longer than the buffer, or when it falls in the tagged-size window while both jumbo and VLAN support are off. Every frame that is forwarded gives a one-cycle completion pulse. Input is held off from the cycle after a frame's last byte is accepted until its final output byte is presented.

Top module: `tx_csum_insert`

## Requirements
- R1: No byte of a frame is output before the frame's last input byte is accepted. The first output byte appears two clock cycles after that acceptance. The bytes follow in order on consecutive cycles, the final one is flagged with `out_last`, and `out_valid` is low in the cycle after it.
- R2: `in_ready` is high in reset and while a frame is being received. It is low from the cycle after the last byte of a forwarded frame is accepted. It goes high again in the cycle in which that frame's final output byte is presented.
- R3: The three sideband words are sampled together with the first byte of a frame. Bit 0 of `sb_ctrl` set to 1 requests checksum insertion. When it is 0 the frame is forwarded byte for byte unchanged.
- R4: `sb_offs[31:16]` is the start offset of the summed region and `sb_offs[15:0]` is the write offset. Both are byte indices counted from 0 at the first byte of the frame.
- R5: The sum adds the low 16 bits of `sb_seed` to the frame bytes from the start offset up to the end of the frame, taken as big-endian 16-bit words. The byte at the start offset is the high byte of the first word. A trailing odd byte is the high byte of a word whose low byte is zero.
- R6: The sum is folded to 16 bits with end-around carry and complemented. The high byte of the result replaces the byte at the write offset and the low byte replaces the byte at write offset + 1.
- R7: When write offset + 1 is not less than the frame length, the frame is forwarded unmodified. When the start offset is at or past the end of the frame, only the seed is summed.
- R8: A frame is dropped, with no output and no completion pulse, when `cfg_tx_en` is 0 at the cycle its last byte is accepted.
- R9: With `cfg_jumbo_en` and `cfg_vlan_en` both 0, frames of 1519 to 1522 bytes are dropped. Frames of 1518 and 1523 bytes are forwarded, and setting either configuration bit forwards the whole window.
- R10: A frame longer than the buffer depth (2048 bytes by default) is dropped. A frame of exactly the depth is forwarded.
- R11: `tx_done` is a one-cycle pulse that coincides with the final output byte of each forwarded frame, and it occurs at no other time.
- R12: After reset, `out_valid`, `out_last` and `tx_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable; 0 drops frames |
| cfg_jumbo_en | input | 1 | Jumbo frames allowed |
| cfg_vlan_en | input | 1 | Tagged frames allowed |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| sb_ctrl | input | 32 | Sideband control; bit 0 enables insertion |
| sb_offs | input | 32 | Start offset [31:16], write offset [15:0] |
| sb_seed | input | 32 | Seed for the sum in bits [15:0] |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last of its frame |
| tx_done | output | 1 | Completion pulse for a forwarded frame |

## Verification
The bound checker looks at the shape of the output burst on every cycle: bytes are contiguous, `out_valid` drops right after the last byte, `tx_done` and `out_last` line up, and input is never accepted while a burst is still in progress. None of these properties can see data values. Byte values, checksum results, the odd-length pad, the write-offset range rule and the drop rules for size, overflow and transmit enable are shown only by the bench. Its reference model predicts each forwarded frame byte by byte and compares it with every output byte.

// File: rtl/tcsi_pkg.sv
package tcsi_pkg;
   typedef enum logic [1:0] {
      ST_FILL  = 2'd0,
      ST_FOLD  = 2'd1,
      ST_DRAIN = 2'd2
   } tcsi_state_e;

   localparam int OFF_W      = 16;
   localparam int CTRL_EN    = 0;
   localparam int START_LSB  = 16;
   localparam int WRITE_LSB  = 0;
endpackage

// File: rtl/tcsi_frame_buf.sv
module tcsi_frame_buf #(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   assign rd_data = store[rd_addr];
endmodule

// File: rtl/tcsi_sum_accum.sv
module tcsi_sum_accum #(
   parameter int SUM_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             first,
   input  logic [15:0]      seed,
   input  logic             use_byte,
   input  logic             hi,
   input  logic [7:0]       data,
   output logic [SUM_W-1:0] sum
);
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W-1:0] contrib;
   logic [SUM_W-1:0] base;

   always_comb begin
      contrib = '0;
      if (use_byte) begin
         if (hi) contrib = SUM_W'({data, 8'h00});
         else    contrib = SUM_W'(data);
      end
      base = first ? SUM_W'(seed) : sum_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sum_q <= '0;
      else if (en) sum_q <= base + contrib;
   end

   assign sum = sum_q;
endmodule

// File: rtl/tcsi_fold.sv
module tcsi_fold #(
   parameter int SUM_W = 28
) (
   input  logic [SUM_W-1:0] sum_i,
   output logic [15:0]      csum_o
);
   localparam int NPASS = (SUM_W <= 32) ? 2 : 3;

   logic [SUM_W-1:0] stage [NPASS+1];

   assign stage[0] = sum_i;

   for (genvar p = 0; p < NPASS; p++) begin : g_pass
      assign stage[p+1] = SUM_W'(stage[p][15:0]) + (stage[p] >> 16);
   end

   assign csum_o = ~stage[NPASS][15:0];
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
   import tcsi_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int STD_MAX = 1518,
   parameter int TAG_MAX = 1522
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_tx_en,
   input  logic        cfg_jumbo_en,
   input  logic        cfg_vlan_en,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [7:0]  in_data,
   input  logic        in_last,
   input  logic [31:0] sb_ctrl,
   input  logic [31:0] sb_offs,
   input  logic [31:0] sb_seed,
   output logic        out_valid,
   output logic [7:0]  out_data,
   output logic        out_last,
   output logic        tx_done
);
   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = AW + 1;
   localparam int SUM_W = 17 + AW;

   initial begin
      if (DEPTH < TAG_MAX + 1)   $error("DEPTH must hold a tagged frame");
      if (CNT_W > 15)            $error("DEPTH too large for 16-bit offsets");
      if (STD_MAX >= TAG_MAX)    $error("size window is empty");
      if (SUM_W > 48)            $error("sum width out of range");
   end

   tcsi_state_e       state_q;
   logic [CNT_W-1:0]  pos_q;
   logic              ovf_q;
   logic              ins_en_q;
   logic [OFF_W-1:0]  start_q;
   logic [OFF_W-1:0]  wo_q;
   logic [CNT_W-1:0]  len_q;
   logic              patch_q;
   logic [15:0]       csum_q;
   logic [CNT_W-1:0]  rd_ptr_q;
   logic              out_valid_q, out_last_q, tx_done_q;
   logic [7:0]        out_data_q;

   logic              accept, first, at_cap, drop;
   logic [OFF_W-1:0]  eff_start, pos16, rel, len16, rd16;
   logic              in_region;
   logic [SUM_W-1:0]  sum;
   logic [15:0]       fold_csum;
   logic [7:0]        rd_data;
   logic [16:0]       wo_end;
   logic              sb_unused;

   assign sb_unused = ^{sb_ctrl[31:1], sb_seed[31:16]};

   assign in_ready  = (state_q == ST_FILL);
   assign accept    = in_valid && in_ready;
   assign first     = (pos_q == '0);
   assign at_cap    = (pos_q == CNT_W'(DEPTH));
   assign eff_start = first ? sb_offs[START_LSB +: OFF_W] : start_q;
   assign pos16     = OFF_W'(pos_q);
   assign rel       = pos16 - eff_start;
   assign in_region = (pos16 >= eff_start);
   assign len16     = OFF_W'(pos_q + 1'b1);
   assign rd16      = OFF_W'(rd_ptr_q);
   assign wo_end    = {1'b0, wo_q} + 17'd2;

   always_comb begin
      drop = !cfg_tx_en || ovf_q || at_cap;
      if (!cfg_jumbo_en && !cfg_vlan_en &&
          len16 > OFF_W'(STD_MAX) && len16 <= OFF_W'(TAG_MAX))
         drop = 1'b1;
   end

   tcsi_frame_buf #(.DEPTH(DEPTH), .AW(AW)) i_buf (
      .clk     (clk),
      .wr_en   (accept && !at_cap && !ovf_q),
      .wr_addr (pos_q[AW-1:0]),
      .wr_data (in_data),
      .rd_addr (rd_ptr_q[AW-1:0]),
      .rd_data (rd_data)
   );

   tcsi_sum_accum #(.SUM_W(SUM_W)) i_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (accept),
      .first    (first),
      .seed     (sb_seed[15:0]),
      .use_byte (in_region),
      .hi       (~rel[0]),
      .data     (in_data),
      .sum      (sum)
   );

   tcsi_fold #(.SUM_W(SUM_W)) i_fold (
      .sum_i  (sum),
      .csum_o (fold_csum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_FILL;
         pos_q       <= '0;
         ovf_q       <= 1'b0;
         ins_en_q    <= 1'b0;
         start_q     <= '0;
         wo_q        <= '0;
         len_q       <= '0;
         patch_q     <= 1'b0;
         csum_q      <= '0;
         rd_ptr_q    <= '0;
         out_valid_q <= 1'b0;
         out_last_q  <= 1'b0;
         tx_done_q   <= 1'b0;
         out_data_q  <= '0;
      end else begin
         out_valid_q <= 1'b0;
         out_last_q  <= 1'b0;
         tx_done_q   <= 1'b0;
         case (state_q)
            ST_FILL: begin
               if (accept) begin
                  if (first) begin
                     ins_en_q <= sb_ctrl[CTRL_EN];
                     start_q  <= sb_offs[START_LSB +: OFF_W];
                     wo_q     <= sb_offs[WRITE_LSB +: OFF_W];
                  end
                  if (in_last) begin
                     pos_q <= '0;
                     ovf_q <= 1'b0;
                     if (!drop) begin
                        len_q   <= pos_q + 1'b1;
                        state_q <= ST_FOLD;
                     end
                  end else if (at_cap) begin
                     ovf_q <= 1'b1;
                  end else begin
                     pos_q <= pos_q + 1'b1;
                  end
               end
            end
            ST_FOLD: begin
               csum_q   <= fold_csum;
               patch_q  <= ins_en_q && (wo_end <= 17'(len_q));
               rd_ptr_q <= '0;
               state_q  <= ST_DRAIN;
            end
            ST_DRAIN: begin
               out_valid_q <= 1'b1;
               if (patch_q && rd16 == wo_q)
                  out_data_q <= csum_q[15:8];
               else if (patch_q && rd16 == wo_q + 1'b1)
                  out_data_q <= csum_q[7:0];
               else
                  out_data_q <= rd_data;
               rd_ptr_q <= rd_ptr_q + 1'b1;
               if (rd_ptr_q == len_q - 1'b1) begin
                  out_last_q <= 1'b1;
                  tx_done_q  <= 1'b1;
                  state_q    <= ST_FILL;
               end
            end
            default: state_q <= ST_FILL;
         endcase
      end
   end

   assign out_valid = out_valid_q;
   assign out_data  = out_data_q;
   assign out_last  = out_last_q;
   assign tx_done   = tx_done_q;
endmodule

// File: rtl/tcsi_checker.sv
module tcsi_checker (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid,
   input logic out_last,
   input logic tx_done
);
   assert_input_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |-> !in_ready);

   assert_burst_contiguous_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   assert_gap_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   assert_last_is_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_done_on_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> out_last);

   assert_last_gives_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> tx_done);

   assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !out_last) |-> !out_valid);
endmodule

bind tx_csum_insert tcsi_checker i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_last  (out_last),
   .tx_done   (tx_done)
);

// File: tb/test_tx_csum_insert.sv
`timescale 1ns/1ps
module test_tx_csum_insert;
   localparam int DEPTH = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_tx_en = 1'b1, cfg_jumbo_en = 1'b0, cfg_vlan_en = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready;
   logic [31:0] sb_ctrl = '0, sb_offs = '0, sb_seed = '0;
   logic        out_valid, out_last, tx_done;
   logic [7:0]  out_data;

   int checks = 0, fails = 0, done_cnt = 0, fwd_cnt = 0;
   bit finished = 0;
   string cur_req = "R12";
   int exp_q[$];
   bit last_q[$];
   logic [7:0] fbuf [0:4095];

   always #2 clk = ~clk;

   tx_csum_insert #(.DEPTH(DEPTH)) i_tx_csum_insert (
      .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_jumbo_en(cfg_jumbo_en),
      .cfg_vlan_en(cfg_vlan_en), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .sb_ctrl(sb_ctrl), .sb_offs(sb_offs),
      .sb_seed(sb_seed), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .tx_done(tx_done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // per-byte comparison against the model's queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_done) done_cnt++;
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               chk(0, {cur_req, " unexpected output"}, out_data, 0);
            end else begin
               int e;
               bit l;
               e = exp_q.pop_front();
               l = last_q.pop_front();
               chk(out_data == e[7:0], {cur_req, " data"}, out_data, e);
               chk(out_last == l, {cur_req, " R1 last flag"}, out_last, l);
               chk(tx_done == l, {cur_req, " R11 done"}, tx_done, l);
               if (!l) chk(!in_ready, {cur_req, " R2 ready low"}, in_ready, 0);
            end
         end else begin
            chk(!tx_done, {cur_req, " R11 stray done"}, tx_done, 0);
         end
      end
   end

   task automatic send(input int len, input int kind, input bit ins, input int st,
                       input int wo, input int seed, input bit tx, input bit jum,
                       input bit vlan, input string req);
      int sum;
      bit fwd;
      logic [7:0] mb [0:4095];
      cur_req = req;
      for (int i = 0; i < len; i++) begin
         fbuf[i] = (kind == 1) ? 8'hFF : 8'((i * 13 + len + kind) & 255);
         mb[i] = fbuf[i];
      end
      fwd = tx && len <= DEPTH && !(!jum && !vlan && len >= 1519 && len <= 1522);
      if (fwd) begin
         sum = seed & 16'hFFFF;
         for (int i = st; i < len; i += 2)
            sum += {fbuf[i], (i + 1 < len) ? fbuf[i+1] : 8'h00};
         while (sum > 32'hFFFF) sum = (sum & 32'hFFFF) + (sum >> 16);
         sum = (~sum) & 32'hFFFF;
         if (ins && wo + 1 < len) begin
            mb[wo] = sum[15:8];
            mb[wo+1] = sum[7:0];
         end
         for (int i = 0; i < len; i++) begin
            exp_q.push_back(int'(mb[i]));
            last_q.push_back(i == len - 1);
         end
         fwd_cnt++;
      end
      while (!in_ready) @(negedge clk);
      cfg_tx_en = tx; cfg_jumbo_en = jum; cfg_vlan_en = vlan;
      sb_ctrl = {31'd0, ins};
      sb_offs = {st[15:0], wo[15:0]};
      sb_seed = {16'hA5A5, seed[15:0]};
      for (int i = 0; i < len; i++) begin
         in_valid = 1'b1;
         in_data  = fbuf[i];
         in_last  = (i == len - 1);
         @(negedge clk);
      end
      in_valid = 1'b0; in_last = 1'b0;
      sb_ctrl = 32'hFFFF_FFFF; sb_offs = '0; sb_seed = 32'h1234_5678;
      if (fwd) begin
         chk(!out_valid, {req, " R1 no early output"}, out_valid, 0);
         @(negedge clk);
         chk(!out_valid && !in_ready, {req, " R1/R2 fold cycle"}, {out_valid, in_ready}, 0);
         @(negedge clk);
         chk(out_valid, {req, " R1 first byte timing"}, out_valid, 1);
         repeat (len + 1) @(negedge clk);
         chk(in_ready, {req, " R2 ready back"}, in_ready, 1);
      end else begin
         for (int k = 0; k < 4; k++) begin
            chk(!out_valid && in_ready, {req, " dropped, no output"}, {out_valid, in_ready}, 1);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!out_valid && !out_last && !tx_done && in_ready, "R12 reset state",
          {out_valid, out_last, tx_done, in_ready}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && in_ready, "R12 after reset", {out_valid, in_ready}, 1);

      send(64,  0, 0, 0,   0,   0,      1, 0, 0, "R3 plain forward");
      send(60,  0, 1, 14,  24,  16'h1234, 1, 0, 0, "R4 R5 R6 even length");
      send(61,  0, 1, 14,  40,  16'h0,    1, 0, 0, "R5 odd pad");
      send(33,  2, 1, 0,   0,   16'h8001, 1, 0, 0, "R4 start zero");
      send(40,  0, 1, 3,   38,  16'h00FF, 1, 0, 0, "R7 last legal write");
      send(40,  0, 1, 3,   39,  16'h00FF, 1, 0, 0, "R7 write outside");
      send(40,  0, 1, 50,  10,  16'hBEEF, 1, 0, 0, "R7 start past end");
      send(100, 1, 1, 0,   20,  16'hFFFF, 1, 0, 0, "R6 carry fold");
      send(1,   0, 1, 0,   0,   16'h1111, 1, 0, 0, "R1 single byte");
      send(50,  0, 1, 2,   4,   16'h0,    0, 0, 0, "R8 tx disabled");
      send(50,  0, 0, 0,   0,   0,      1, 0, 0, "R8 after drop");
      send(1518, 0, 1, 14, 30,  16'h0102, 1, 0, 0, "R9 1518 forwarded");
      send(1519, 0, 0, 0,   0,  0,      1, 0, 0, "R9 1519 dropped");
      send(1522, 0, 0, 0,   0,  0,      1, 0, 0, "R9 1522 dropped");
      send(1523, 0, 0, 0,   0,  0,      1, 0, 0, "R9 1523 forwarded");
      send(1520, 0, 0, 0,   0,  0,      1, 0, 1, "R9 vlan on");
      send(1521, 0, 0, 0,   0,  0,      1, 1, 0, "R9 jumbo on");
      send(DEPTH + 1, 0, 0, 0, 0, 0,    1, 1, 0, "R10 overflow dropped");
      send(DEPTH, 0, 1, 100, DEPTH - 2, 16'h7777, 1, 1, 0, "R10 full depth");
      send(20,  0, 1, 1,   5,   16'h4242, 1, 0, 0, "R10 after overflow");

      repeat (5) @(negedge clk);
      cur_req = "R11";
      chk(done_cnt == fwd_cnt, "R11 pulse count", done_cnt, fwd_cnt);
      chk(exp_q.size() == 0, "R1 all bytes delivered", exp_q.size(), 0);
      summary();
   end
endmodule